// File: doc/BRIEF.md
# Cache Upset Injector

This unit sits beside a cache data array and emulates radiation-induced upsets at an accelerated rate. Each cycle it is enabled, it steps a 32-bit pseudo-random generator and compares the value with a threshold. The threshold is the programmed per-kilobyte rate multiplied by the array capacity in kilobytes, so a larger array takes more upsets. When the value falls below the threshold, other fields of the same value pick a line, a word within the line and a bit position.

The array reports which lines hold valid data. If the chosen line is valid, the unit sends the array a one-cycle strobe with the line, word and inversion mask. The array then XORs the mask into the stored word, which gives a transient upset and not a stuck fault. About one event in a hundred inverts two neighbouring bits; every other event inverts one bit. Two saturating counters record how many single and double inversions were issued.

Top module: `seu_injector`

## Requirements
- R1: During and after reset, with no enabled cycle yet, `flip_stb` is 0, `flip_line`, `flip_word`, `flip_mask` and both counters are 0, and the generator state is the parameter `SEED_RST` (default 32'h1D87_2B41).
- R2: The generator state s advances as s' = {s[30:0], s[31]^s[21]^s[1]^s[0]} once for each cycle in which `inj_en` is 1 and `seed_load` is 0. In any other cycle s is held.
- R3: When `seed_load` is 1, s takes `seed_val` at the next edge, or 32'h1 if `seed_val` is zero. This has priority over `inj_en`, and no event is produced in that cycle.
- R4: An event happens in an advancing cycle when s (the value before the step) is below T. T is `base_rate * CACHE_KB`, saturated to 32'hFFFF_FFFF.
- R5: For an event, the line is s[LW-1:0], the word is the next WW bits and the bit position is the next BW bits, with LW, WW and BW the log2 of lines, words per line and word width (defaults: s[3:0], s[6:4], s[11:7]).
- R6: An event whose selected line has its `line_valid` bit at 0 issues no strobe and is not counted.
- R7: If s[15:0] mod 100 is 0, the event inverts the two adjacent bits p and p+1, or the top two bits when p is the last bit. Otherwise it inverts bit p only.
- R8: A valid event raises `flip_stb` for exactly one cycle, starting at the edge that ends the deciding cycle, together with line, word and mask. While `flip_stb` is 0, line, word and mask read 0.
- R9: `sbu_count` counts single-bit strobes and `mbu_count` counts double-bit strobes. Each stops at its maximum value instead of wrapping.
- R10: While `inj_en` is 0, no strobe is issued and the counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Global injection enable |
| seed_load | input | 1 | Load `seed_val` into the generator |
| seed_val | input | 32 | Generator seed (zero is replaced by 1) |
| base_rate | input | 32 | Upset threshold per kilobyte of array |
| line_valid | input | NUM_LINES | Per-line valid flags from the array |
| flip_stb | output | 1 | One-cycle inversion request |
| flip_line | output | LW | Line to upset |
| flip_word | output | WW | Word within the line |
| flip_mask | output | WORD_BITS | Bits to invert |
| sbu_count | output | CNT_W | Single-bit upsets issued, saturating |
| mbu_count | output | CNT_W | Double-bit upsets issued, saturating |

## Verification
The bench drives the injector with several threshold settings. A threshold of zero must give no events. A threshold whose product overflows must saturate, so nearly every cycle fires. A mid threshold fires about half the time and shows whether the comparison is strict and uses the state before the step. A valid map with only alternate lines set separates line gating from the threshold decision. A zero seed, a disabled stretch followed by re-enabling, and a counter width small enough to saturate cover the generator's hold and reload behaviour and the counter limits. Each cycle's strobe, location, mask and counts are compared with a model written from the requirements.

// File: rtl/seu_pkg.sv
package seu_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_SINGLE = 2'd1,
    EV_DOUBLE = 2'd2
  } ev_kind_e;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/seu_lfsr.sv
module seu_lfsr #(
  parameter logic [31:0] SEED_RST = 32'h1D87_2B41
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] state
);
  logic [31:0] state_n;

  always_comb begin
    state_n = state;
    if (load)     state_n = (load_val == 32'd0) ? 32'd1 : load_val;
    else if (adv) state_n = seu_pkg::lfsr_step(state);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED_RST;
    else        state <= state_n;
  end

  // R2: the state never becomes zero
  a_r2_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    state != 32'd0);
  // R3: a load lands exactly
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load && load_val != 32'd0 |=> state == $past(load_val));
endmodule

// File: rtl/seu_event_gen.sv
module seu_event_gen #(
  parameter int NUM_LINES      = 16,
  parameter int WORDS_PER_LINE = 8,
  parameter int WORD_BITS      = 32,
  parameter int CACHE_KB       = 32,
  parameter int MBU_PERIOD     = 100,
  localparam int LW  = $clog2(NUM_LINES),
  localparam int WW  = $clog2(WORDS_PER_LINE),
  localparam int BW  = $clog2(WORD_BITS),
  localparam int KBW = $clog2(CACHE_KB + 1),
  localparam int PW  = 32 + KBW
) (
  input  logic [31:0]          state,
  input  logic                 active,
  input  logic [31:0]          base_rate,
  input  logic [NUM_LINES-1:0] line_valid,
  output seu_pkg::ev_kind_e    kind,
  output logic [LW-1:0]        line,
  output logic [WW-1:0]        word,
  output logic [WORD_BITS-1:0] mask
);
  logic [PW-1:0]    prod;
  logic [31:0]      thresh;
  logic [BW-1:0]    bitpos;
  logic             hit, dbl;
  logic [15:0]      type_field;

  assign prod   = PW'(base_rate) * PW'(CACHE_KB);
  assign thresh = (|prod[PW-1:32]) ? 32'hFFFF_FFFF : prod[31:0];

  assign line       = state[LW-1:0];
  assign word       = state[LW+WW-1:LW];
  assign bitpos     = state[LW+WW+BW-1:LW+WW];
  assign type_field = state[15:0];

  assign hit = active && (state < thresh) && line_valid[line];
  assign dbl = (type_field % 16'(MBU_PERIOD)) == 16'd0;

  always_comb begin
    kind = seu_pkg::EV_NONE;
    mask = '0;
    if (hit) begin
      if (dbl) begin
        kind = seu_pkg::EV_DOUBLE;
        if (bitpos == BW'(WORD_BITS - 1))
          mask = WORD_BITS'(3) << (WORD_BITS - 2);
        else
          mask = WORD_BITS'(3) << bitpos;
      end else begin
        kind = seu_pkg::EV_SINGLE;
        mask = WORD_BITS'(1) << bitpos;
      end
    end
  end
endmodule

// File: rtl/seu_sat_counter.sv
module seu_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_n;

  always_comb begin
    count_n = count;
    if (inc && count != '1) count_n = count + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_n;
  end

  // R9: the count never wraps back to zero
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(count) == '1 |-> count == '1);
endmodule

// File: rtl/seu_injector.sv
module seu_injector #(
  parameter int          NUM_LINES      = 16,
  parameter int          WORDS_PER_LINE = 8,
  parameter int          WORD_BITS      = 32,
  parameter int          CACHE_KB       = 32,
  parameter int          MBU_PERIOD     = 100,
  parameter int          CNT_W          = 16,
  parameter logic [31:0] SEED_RST       = 32'h1D87_2B41,
  localparam int LW = $clog2(NUM_LINES),
  localparam int WW = $clog2(WORDS_PER_LINE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inj_en,
  input  logic                 seed_load,
  input  logic [31:0]          seed_val,
  input  logic [31:0]          base_rate,
  input  logic [NUM_LINES-1:0] line_valid,
  output logic                 flip_stb,
  output logic [LW-1:0]        flip_line,
  output logic [WW-1:0]        flip_word,
  output logic [WORD_BITS-1:0] flip_mask,
  output logic [CNT_W-1:0]     sbu_count,
  output logic [CNT_W-1:0]     mbu_count
);
  import seu_pkg::*;

  logic [31:0]          lfsr_q;
  logic                 adv;
  ev_kind_e             kind;
  logic [LW-1:0]        ev_line;
  logic [WW-1:0]        ev_word;
  logic [WORD_BITS-1:0] ev_mask;
  logic                 stb_n;
  logic [LW-1:0]        line_n;
  logic [WW-1:0]        word_n;
  logic [WORD_BITS-1:0] mask_n;
  logic [1:0]           inc_vec;
  logic [CNT_W-1:0]     cnt_arr [2];

  assign adv = inj_en && !seed_load;

  seu_lfsr #(.SEED_RST(SEED_RST)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(seed_load),
    .load_val(seed_val), .state(lfsr_q)
  );

  seu_event_gen #(
    .NUM_LINES(NUM_LINES), .WORDS_PER_LINE(WORDS_PER_LINE),
    .WORD_BITS(WORD_BITS), .CACHE_KB(CACHE_KB), .MBU_PERIOD(MBU_PERIOD)
  ) u_evgen (
    .state(lfsr_q), .active(adv), .base_rate(base_rate),
    .line_valid(line_valid), .kind(kind), .line(ev_line),
    .word(ev_word), .mask(ev_mask)
  );

  always_comb begin
    stb_n  = (kind != EV_NONE);
    line_n = stb_n ? ev_line : '0;
    word_n = stb_n ? ev_word : '0;
    mask_n = ev_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_stb  <= 1'b0;
      flip_line <= '0;
      flip_word <= '0;
      flip_mask <= '0;
    end else begin
      flip_stb  <= stb_n;
      flip_line <= line_n;
      flip_word <= word_n;
      flip_mask <= mask_n;
    end
  end

  assign inc_vec[0] = (kind == EV_SINGLE);
  assign inc_vec[1] = (kind == EV_DOUBLE);

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    seu_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(inc_vec[k]), .count(cnt_arr[k])
    );
  end

  assign sbu_count = cnt_arr[0];
  assign mbu_count = cnt_arr[1];

  // R6: a strobe only targets a line that was valid when chosen
  a_r6_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb |-> ((($past(line_valid) >> flip_line) & NUM_LINES'(1)) != '0));
  // R10: a disabled cycle gives no strobe
  a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inj_en) |-> !flip_stb);
  // R7: a strobe inverts one bit or two adjacent bits
  a_r7_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb |-> ($countones(flip_mask) == 1 ||
                  ($countones(flip_mask) == 2 && (flip_mask & (flip_mask >> 1)) != '0)));
  // R8: fields are quiet without a strobe
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_stb |-> (flip_mask == '0 && flip_line == '0 && flip_word == '0));
  // R9: a single-bit strobe moves the single counter by one unless saturated
  a_r9_sbu_step: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb && $countones(flip_mask) == 1 && $past(sbu_count) != '1
      |-> sbu_count == $past(sbu_count) + CNT_W'(1));
  // R9: a double-bit strobe leaves the single counter alone
  a_r9_sbu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    flip_stb && $countones(flip_mask) == 2 |-> $stable(sbu_count));
endmodule

// File: tb/seu_injector_test.sv
`timescale 1ns/1ps
module seu_injector_test;
  localparam int          NL   = 16;
  localparam int          NW   = 8;
  localparam int          WB   = 32;
  localparam int          KB   = 32;
  localparam int          CW   = 6;
  localparam logic [31:0] SRST = 32'h1D87_2B41;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          inj_en, seed_load;
  logic [31:0]   seed_val, base_rate;
  logic [NL-1:0] line_valid;
  logic          flip_stb;
  logic [3:0]    flip_line;
  logic [2:0]    flip_word;
  logic [WB-1:0] flip_mask;
  logic [CW-1:0] sbu_count, mbu_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // model state
  logic [31:0]   m_s;
  logic [CW-1:0] m_sbu, m_mbu;
  logic          e_stb;
  logic [3:0]    e_line;
  logic [2:0]    e_word;
  logic [WB-1:0] e_mask;
  int            mbu_seen;

  always #2.5 clk = ~clk;

  seu_injector #(
    .NUM_LINES(NL), .WORDS_PER_LINE(NW), .WORD_BITS(WB),
    .CACHE_KB(KB), .MBU_PERIOD(100), .CNT_W(CW), .SEED_RST(SRST)
  ) uut (
    .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .seed_load(seed_load),
    .seed_val(seed_val), .base_rate(base_rate), .line_valid(line_valid),
    .flip_stb(flip_stb), .flip_line(flip_line), .flip_word(flip_word),
    .flip_mask(flip_mask), .sbu_count(sbu_count), .mbu_count(mbu_count)
  );

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [31:0] thr(input logic [31:0] r);
    logic [63:0] p;
    p = 64'(r) * 64'(KB);
    return (p > 64'hFFFF_FFFF) ? 32'hFFFF_FFFF : p[31:0];
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  // one clock: predict from pre-edge model, then compare after the edge
  task automatic tick(input string tag);
    logic [4:0] p;
    e_stb = 1'b0; e_line = '0; e_word = '0; e_mask = '0;
    if (seed_load) begin
      m_s = (seed_val == 0) ? 32'd1 : seed_val;
    end else if (inj_en) begin
      if (m_s < thr(base_rate) && line_valid[m_s[3:0]]) begin
        e_stb  = 1'b1;
        e_line = m_s[3:0];
        e_word = m_s[6:4];
        p      = m_s[11:7];
        if (m_s[15:0] % 100 == 0) begin
          e_mask = (p == 5'd31) ? (WB'(3) << 30) : (WB'(3) << p);
          if (m_mbu != '1) m_mbu++;
          mbu_seen++;
        end else begin
          e_mask = WB'(1) << p;
          if (m_sbu != '1) m_sbu++;
        end
      end
      m_s = nxt(m_s);
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, {flip_stb, flip_line, flip_word, flip_mask, sbu_count, mbu_count},
             {e_stb, e_line, e_word, e_mask, m_sbu, m_mbu});
  endtask

  task automatic t_reset();
    rst_n = 1'b0; inj_en = 0; seed_load = 0; seed_val = 0;
    base_rate = 0; line_valid = '1;
    m_s = SRST; m_sbu = 0; m_mbu = 0; mbu_seen = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {flip_stb, flip_line, flip_word, flip_mask, sbu_count, mbu_count}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {flip_stb, sbu_count, mbu_count}, '0);
  endtask

  task automatic t_disabled();
    inj_en = 0; base_rate = 32'hFFFF_FFFF;
    for (int i = 0; i < 40; i++) tick("R10 disabled");
    // R2: first enabled cycle must use the untouched reset state
    inj_en = 1;
    for (int i = 0; i < 40; i++) tick("R2 resume from held state");
  endtask

  task automatic t_zero_rate();
    base_rate = 0; inj_en = 1;
    for (int i = 0; i < 100; i++) tick("R4 zero threshold");
  endtask

  task automatic t_full_rate();
    base_rate = 32'h0800_0000; // product 2^32 saturates
    line_valid = '1;
    for (int i = 0; i < 3000; i++) tick("R4 R5 R7 R8 saturated threshold");
    chk("R7 double events occurred", 128'(mbu_seen > 0), 128'(1));
  endtask

  task automatic t_mid_rate();
    base_rate = 32'h0400_0000; // threshold 2^31
    for (int i = 0; i < 1000; i++) tick("R4 mid threshold");
  endtask

  task automatic t_sparse_valid();
    base_rate = 32'hFFFF_FFFF; line_valid = 16'h5555;
    for (int i = 0; i < 1000; i++) tick("R6 alternate lines valid");
    line_valid = '1;
  endtask

  task automatic t_seed();
    seed_load = 1; seed_val = 32'd0; inj_en = 1;
    tick("R3 zero seed load");
    seed_load = 0;
    for (int i = 0; i < 200; i++) tick("R3 after zero seed");
    seed_load = 1; seed_val = 32'hC0DE_0640;
    inj_en = 0;
    tick("R3 load while disabled");
    seed_load = 0; inj_en = 1;
    for (int i = 0; i < 500; i++) tick("R3 after seed");
  endtask

  task automatic t_saturation();
    base_rate = 32'hFFFF_FFFF;
    for (int i = 0; i < 200; i++) tick("R9 saturation run");
    chk("R9 single counter pinned at max", 128'(sbu_count), 128'({CW{1'b1}}));
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_zero_rate();
    t_full_rate();
    t_mid_rate();
    t_sparse_valid();
    t_seed();
    t_saturation();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule